// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is one timer channel behind a 32-bit register interface. A down-counter advances on steps produced by a prescaler, which divides a timer clock enable pulse by 1, 16 or 256. When the count runs out the channel raises a raw interrupt flag and then does one of three things, depending on its mode:

- In free-running mode it wraps to the largest value for the selected width.
- In periodic mode it reloads a programmed value.
- In one-shot mode it stops at zero.

The counter can work as 16 or 32 bits wide. Software can change the reload value in two ways. One write restarts the count at once. A second, background write only takes effect at the next reload. Raw and masked interrupt status are readable separately, and the interrupt output is the masked flag.

The bus is synchronous. The word address, write enable and write data are sampled on the rising clock edge. Read data is a combinational decode of the current address. A system places the channel in its address map and drives the tick input from a slower timer clock, turned into one-cycle enable pulses.

Top module: `tmr_top`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only, timer stopped). The count, the reload value, the raw flag, the masked status and the interrupt output are all zero.
- R2: Word addresses are decoded as follows:
  - Address 0: reload-and-restart.
  - Address 1: current count.
  - Address 2: control, which reads back as 8 bits zero-extended.
  - Address 3: interrupt clear.
  - Address 4: raw status in bit 0.
  - Address 5: masked status in bit 0.
  - Address 6: background reload.
  - Addresses 3 and 7 read as zero, and a write to address 7 has no effect.
  - Control bits: bit 0 is one-shot, bit 1 is 32-bit width, bits 3:2 are the prescaler code, bit 5 is interrupt enable, bit 6 is periodic and bit 7 is run.
- R3: A write to address 0 sets the reload value and loads the counter in the same edge. Reads of addresses 0 and 6 both return the full 32-bit reload value.
- R4: A write to address 6 changes the reload value without touching the current count. The new value is used at the next periodic reload.
- R5: While running, the counter decrements once per 1, 16 or 256 tick pulses, for prescaler codes 00, 01 and 10; code 11 divides by 1. Any control write restarts the prescaler phase from zero.
- R6: A step taken while the effective count is 1 or 0 is an expiry, and it sets the raw flag. In periodic mode the counter then loads the reload value. In free-running mode it loads 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit).
- R7: In one-shot mode an expiry leaves the count at 0 and ignores further steps. Counting resumes after a write to address 0, or after a control write that sets run while run was clear.
- R8: With the width bit clear, only the low 16 bits count and take part in the expiry check, and the upper 16 bits of the count read as zero.
- R9: Any write to address 3 clears the raw flag. An expiry in the same cycle wins and leaves the flag set.
- R10: The interrupt output and the masked status both equal the raw flag ANDed with control bit 5.
- R11: Writes to address 1 have no effect on the count.
- R12: With the run bit clear, tick pulses do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle timer clock enable pulse |
| busWe | input | 1 | Write strobe |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Masked level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit prescaler counter and a middle divide of 16. These values put both the 16-bit and the 32-bit wrap values, and the full divide-by-256 phase, within a few hundred tick pulses. Tick pulses are issued one at a time, so the count after every step can be predicted exactly. This includes steps that coincide with an interrupt clear, and the prescaler phase across a control rewrite.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int CTL_W  = 8;

  localparam int B_ONESHOT = 0;
  localparam int B_WIDE    = 1;
  localparam int B_PRE_LO  = 2;
  localparam int B_PRE_HI  = 3;
  localparam int B_IE      = 5;
  localparam int B_PER     = 6;
  localparam int B_RUN     = 7;

  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_VALUE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ICLR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] A_BGLOAD = 3'd6;

  localparam logic [CTL_W-1:0] CTL_RST = 8'h20;

  typedef struct packed {
    logic loadNow;
    logic loadBg;
    logic step;
    logic wide;
    logic periodic;
    logic oneShot;
    logic restart;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PRE_W     = 8,
  parameter int MID_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              expire,
  output tmrStrobe_t        strb,
  output logic [CTL_W-1:0]  ctlReg,
  output logic              rawFlag
);
  localparam logic [PRE_W-1:0] DIV_MID = PRE_W'((1 << MID_SHIFT) - 1);
  localparam logic [PRE_W-1:0] DIV_MAX = '1;

  logic             ctlWr;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divTop;
  logic             preTerm;
  logic             running;

  assign ctlWr   = busWe && (busAddr == A_CTRL);
  assign running = ctlReg[B_RUN];

  always_comb begin
    case (ctlReg[B_PRE_HI:B_PRE_LO])
      2'b01:   divTop = DIV_MID;
      2'b10:   divTop = DIV_MAX;
      default: divTop = '0;
    endcase
  end

  assign preTerm = (preCnt == divTop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= CTL_RST;
    end else if (ctlWr) begin
      ctlReg <= busWdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctlWr) begin
      preCnt <= '0;
    end else if (tickEn && running) begin
      preCnt <= preTerm ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawFlag <= 1'b0;
    end else if (expire) begin
      rawFlag <= 1'b1;
    end else if (busWe && (busAddr == A_ICLR)) begin
      rawFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.loadNow  = busWe && (busAddr == A_LOAD);
    strb.loadBg   = busWe && (busAddr == A_BGLOAD);
    strb.step     = tickEn && running && !ctlWr && preTerm;
    strb.wide     = ctlReg[B_WIDE];
    strb.periodic = ctlReg[B_PER];
    strb.oneShot  = ctlReg[B_ONESHOT];
    strb.restart  = ctlWr && busWdata[B_RUN] && !ctlReg[B_RUN];
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] countEff,
  output logic [DATA_W-1:0] reloadVal,
  output logic              expire
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] WRAP_WIDE   = '1;
  localparam logic [DATA_W-1:0] WRAP_NARROW = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE         = DATA_W'(1);

  logic [DATA_W-1:0] cntReg;
  logic              halted;
  logic              atEnd;
  logic              advance;

  assign countEff = strb.wide ? cntReg : {{(DATA_W-HALF_W){1'b0}}, cntReg[HALF_W-1:0]};
  assign atEnd    = (countEff <= ONE);
  assign advance  = strb.step && !halted && !strb.loadNow;
  assign expire   = advance && atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg    <= '0;
      reloadVal <= '0;
      halted    <= 1'b0;
    end else if (strb.loadNow) begin
      cntReg    <= busWdata;
      reloadVal <= busWdata;
      halted    <= 1'b0;
    end else begin
      if (strb.loadBg) begin
        reloadVal <= busWdata;
      end
      if (strb.restart) begin
        halted <= 1'b0;
      end
      if (advance) begin
        if (!atEnd) begin
          cntReg <= cntReg - ONE;
        end else if (strb.oneShot) begin
          cntReg <= '0;
          halted <= 1'b1;
        end else if (strb.periodic) begin
          cntReg <= reloadVal;
        end else begin
          cntReg <= strb.wide ? WRAP_WIDE : WRAP_NARROW;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PRE_W     = 8,
  parameter int MID_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tmrStrobe_t        strb;
  logic [CTL_W-1:0]  ctlReg;
  logic              rawFlag;
  logic              expire;
  logic [DATA_W-1:0] countEff;
  logic [DATA_W-1:0] reloadVal;
  logic              maskedFlag;

  tmr_ctrl #(.DATA_W(DATA_W), .PRE_W(PRE_W), .MID_SHIFT(MID_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .expire(expire), .strb(strb), .ctlReg(ctlReg),
    .rawFlag(rawFlag)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .countEff(countEff), .reloadVal(reloadVal), .expire(expire)
  );

  assign maskedFlag = rawFlag && ctlReg[B_IE];
  assign irqOut     = maskedFlag;

  always_comb begin
    case (busAddr)
      A_LOAD, A_BGLOAD: busRdata = reloadVal;
      A_VALUE:          busRdata = countEff;
      A_CTRL:           busRdata = DATA_W'(ctlReg);
      A_RAW:            busRdata = DATA_W'(rawFlag);
      A_MASKED:         busRdata = DATA_W'(maskedFlag);
      default:          busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [CTL_W-1:0]  ctlReg,
  input logic              rawFlag,
  input logic              expire,
  input logic [DATA_W-1:0] countEff,
  input logic [DATA_W-1:0] reloadVal,
  input logic              irqOut
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[B_IE] |-> !irqOut); // R10
  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> rawFlag); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_ICLR && !expire) |=> !rawFlag); // R9
  AST_VALUE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_VALUE && !ctlReg[B_RUN]) |=> $stable(countEff)); // R11
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_LOAD) |=> (reloadVal == $past(busWdata))); // R3
  AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_BGLOAD && !ctlReg[B_RUN]) |=> $stable(countEff)); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[B_WIDE] |-> (countEff[DATA_W-1:DATA_W/2] == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlReg[B_RUN] && !(busWe && (busAddr == A_LOAD || busAddr == A_CTRL)))
      |=> $stable(countEff)); // R12
endmodule

bind tmr_top tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .ctlReg(ctlReg), .rawFlag(rawFlag), .expire(expire), .countEff(countEff),
  .reloadVal(reloadVal), .irqOut(irqOut)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  tmr_top u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic t_reset();
    rdChk("R1 control", 3'd2, 32'h20);
    rdChk("R1 value", 3'd1, 32'h0);
    rdChk("R1 load", 3'd0, 32'h0);
    rdChk("R1 raw", 3'd4, 32'h0);
    rdChk("R1 masked", 3'd5, 32'h0);
    chk("R1 irq", irqOut, 1'b0);
    rdChk("R2 addr7 reads zero", 3'd7, 32'h0);
    rdChk("R2 addr3 reads zero", 3'd3, 32'h0);
  endtask

  task automatic t_idle();
    wr(3'd0, 32'd10);
    rdChk("R3 load sets count", 3'd1, 32'd10);
    tick(3);
    rdChk("R12 stopped count", 3'd1, 32'd10);
    wr(3'd1, 32'd3);
    rdChk("R11 value write ignored", 3'd1, 32'd10);
    wr(3'd7, 32'hFF);
    rdChk("R2 addr7 write no effect", 3'd2, 32'h20);
  endtask

  task automatic t_periodic();
    wr(3'd2, 32'hE0);
    wr(3'd0, 32'd3);
    tick(2);
    rdChk("R6 decrement", 3'd1, 32'd1);
    rdChk("R6 raw before expiry", 3'd4, 32'd0);
    tick(1);
    rdChk("R6 periodic reload", 3'd1, 32'd3);
    rdChk("R6 raw set", 3'd4, 32'd1);
    chk("R10 irq with enable", irqOut, 1'b1);
    rdChk("R10 masked with enable", 3'd5, 32'd1);
    wr(3'd6, 32'd7);
    rdChk("R4 count kept", 3'd1, 32'd3);
    rdChk("R4 reload read via addr0", 3'd0, 32'd7);
    tick(3);
    rdChk("R4 next reload uses bg", 3'd1, 32'd7);
    wr(3'd3, 32'd0);
    rdChk("R9 clear", 3'd4, 32'd0);
    chk("R10 irq after clear", irqOut, 1'b0);
    tick(7);
    rdChk("R6 raw again", 3'd4, 32'd1);
    wr(3'd2, 32'hC0);
    chk("R10 irq masked", irqOut, 1'b0);
    rdChk("R10 masked status off", 3'd5, 32'd0);
    rdChk("R10 raw kept", 3'd4, 32'd1);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd2);
    tick(1);
    @(negedge clk);
    busWe = 1'b1; busAddr = 3'd3; tickEn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    rdChk("R9 expiry beats clear", 3'd4, 32'd1);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_free32();
    wr(3'd2, 32'h82);
    wr(3'd0, 32'd2);
    tick(2);
    rdChk("R6 wrap 32", 3'd1, 32'hFFFF_FFFF);
    rdChk("R6 raw free", 3'd4, 32'd1);
    chk("R10 irq disabled", irqOut, 1'b0);
    wr(3'd3, 32'd0);
    tick(1);
    rdChk("R6 count after wrap", 3'd1, 32'hFFFF_FFFE);
  endtask

  task automatic t_free16();
    wr(3'd2, 32'h80);
    wr(3'd0, 32'h0001_2345);
    rdChk("R8 upper reads zero", 3'd1, 32'h0000_2345);
    wr(3'd0, 32'h0001_0002);
    rdChk("R3 reload full width", 3'd6, 32'h0001_0002);
    tick(2);
    rdChk("R8 wrap 16", 3'd1, 32'h0000_FFFF);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_oneshot();
    wr(3'd2, 32'hC3);
    wr(3'd0, 32'd2);
    tick(2);
    rdChk("R7 stops at zero", 3'd1, 32'd0);
    rdChk("R7 raw set", 3'd4, 32'd1);
    wr(3'd3, 32'd0);
    tick(3);
    rdChk("R7 held", 3'd1, 32'd0);
    rdChk("R7 no re-expiry", 3'd4, 32'd0);
    wr(3'd0, 32'd4);
    tick(1);
    rdChk("R7 load resumes", 3'd1, 32'd3);
    tick(3);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'h43);
    wr(3'd2, 32'hC3);
    tick(1);
    rdChk("R7 restart re-arms", 3'd4, 32'd1);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_prescale();
    wr(3'd2, 32'hC6);
    wr(3'd0, 32'd5);
    tick(15);
    rdChk("R5 div16 hold", 3'd1, 32'd5);
    tick(1);
    rdChk("R5 div16 step", 3'd1, 32'd4);
    tick(7);
    wr(3'd2, 32'hC6);
    tick(15);
    rdChk("R5 phase reset hold", 3'd1, 32'd4);
    tick(1);
    rdChk("R5 phase reset step", 3'd1, 32'd3);
    wr(3'd2, 32'hCA);
    rdChk("R2 control readback", 3'd2, 32'hCA);
    tick(255);
    rdChk("R5 div256 hold", 3'd1, 32'd3);
    tick(1);
    rdChk("R5 div256 step", 3'd1, 32'd2);
    wr(3'd2, 32'hCE);
    tick(1);
    rdChk("R5 code11 div1", 3'd1, 32'd1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_periodic();
    t_free32();
    t_free16();
    t_oneshot();
    t_prescale();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule